// File: doc/BRIEF.md
# System Clock Divider Controller

This block turns a fast oscillator-rate clock into a periodic clock-enable pulse at a rate set by software. Software selects the rate through one 8-bit control register. It can pick a divide of 1, 2, 4 or 8. It can also enter a power-saving mode that forces a divide of 256. The enable output is meant to qualify the flops of the slower system domain while they keep running on the oscillator clock.

A hardware switchback path takes the controller out of power-saving mode as soon as any wake source is active. It also keeps software from re-entering that mode while a source is still active. A bit in the register raises a stop request, which an external wake-clear input drops. The wake sources arrive as a vector of level signals that are already synchronised and masked. Register writes are single-cycle strobes, and reads are combinational from the register.

Control fields: bits 1:0 hold the divide select, bit 2 holds the power-saving enable, bit 3 holds the switchback enable and bit 4 holds the stop request. Bits 7:5 are unused.

Top module: `sysclk_div_ctrl`

## Requirements
- R1: With bit 2 at 0, bits 1:0 set the number of oscillator cycles between enable pulses: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R2: With bit 2 at 1, enable pulses come every 256 oscillator cycles, whatever bits 1:0 hold.
- R3: A write that arrives while bit 2 currently reads 1 leaves bits 1:0 unchanged. This also applies to a write that clears bit 2.
- R4: If bits 3 and 2 both read 1 and any wake source is high, bit 2 reads 0 one cycle later, provided there is no write in that cycle. The pulse spacing then follows bits 1:0 again.
- R5: A write with bit 2 and bit 3 both 1 while any wake source is high leaves bit 2 at 0.
- R6: Wake sources change nothing in the register when bit 2 is 0. They also change nothing when bit 3 is 0.
- R7: A write with bit 4 at 1 raises the stop output in the next cycle, with the rate unchanged. A wake-clear pulse drops the stop output and bit 4 in the next cycle, and it wins over a simultaneous write.
- R8: After reset, bits 4:0 read 0 and the stop output is low. Bits 7:5 always read 0 and ignore writes.
- R9: The enable output is high for one oscillator cycle every N cycles, where N is the active divide. With N=1 it stays high. Pulses start in the first cycle after reset.
- R10: A new divide value takes effect at the next enable pulse. A gap already in progress completes with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents |
| wake_src | input | NSRC | Switchback source levels, already synchronised and masked |
| wake_clr | input | 1 | Clears the stop request |
| clk_en | output | 1 | System clock-enable pulse |
| stop_req | output | 1 | Stop-mode request level |

## Verification
Register contents and the stop output are registered, so their effect on the read port is due one cycle after the write, wake-source change or wake-clear. The scoreboard holds each expected read value tagged with the cycle number one past the stimulus and compares it only at that cycle. Pulse spacing depends on the divide latched at a pulse, so every gap measurement first waits for a pulse that follows the register change and then counts cycles to the next one. The boundary test instead starts counting at the very pulse where the new value was written, and expects the old gap.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

  localparam int REG_W    = 8;
  localparam int USED_W   = 5;
  localparam int CNT_W    = 8;   // power-saving divide is 2**CNT_W
  localparam int SEL_W    = 2;

  // bit order matters: software sees these positions
  typedef struct packed {
    logic             stop;    // bit 4
    logic             sb_en;   // bit 3
    logic             pm_en;   // bit 2
    logic [SEL_W-1:0] div_sel; // bits 1:0
  } ctl_t;

  // active divide minus one, as loaded into the pulse counter
  function automatic logic [CNT_W-1:0] period_m1(input ctl_t c);
    logic [CNT_W-1:0] one;
    one = CNT_W'(1);
    if (c.pm_en) period_m1 = '1;
    else         period_m1 = (one << c.div_sel) - one;
  endfunction

endpackage

// File: rtl/sclk_src_or.sv
module sclk_src_or #(
  parameter int NSRC = 4
) (
  input  logic [NSRC-1:0] src,
  output logic            any_src
);
  logic [NSRC:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < NSRC; i++) begin : g_or
    assign chain[i+1] = chain[i] | src[i];
  end
  assign any_src = chain[NSRC];
endmodule

// File: rtl/sclk_ctl_reg.sv
module sclk_ctl_reg
  import sclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [USED_W-1:0]  wr_bits,
  input  logic               any_src,
  input  logic               wake_clr,
  output ctl_t               ctl_q,
  output logic               sb_clear_ev,
  output logic               pm_blocked
);
  ctl_t wr_view;
  ctl_t nxt;

  assign wr_view     = ctl_t'(wr_bits);
  assign sb_clear_ev = ctl_q.sb_en & ctl_q.pm_en & any_src;
  assign pm_blocked  = wr_en & wr_view.pm_en & wr_view.sb_en & any_src;

  always_comb begin
    nxt = ctl_q;
    if (wr_en) begin
      nxt.sb_en = wr_view.sb_en;
      nxt.pm_en = wr_view.pm_en;
      nxt.stop  = wr_view.stop;
      if (!ctl_q.pm_en) nxt.div_sel = wr_view.div_sel;
    end
    // switchback: clears the mode and also refuses to set it
    if (nxt.sb_en && any_src) nxt.pm_en = 1'b0;
    if (wake_clr) nxt.stop = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= nxt;
  end
endmodule

// File: rtl/sclk_en_gen.sv
module sclk_en_gen
  import sclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] req_m1,
  output logic             clk_en,
  output logic [CNT_W-1:0] cur_m1
);
  logic [CNT_W-1:0] cnt_q;

  assign clk_en = (cnt_q == cur_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cur_m1 <= '0;
    end else if (clk_en) begin
      cnt_q  <= '0;
      cur_m1 <= req_m1;   // new divide only at a boundary
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sysclk_div_ctrl.sv
module sysclk_div_ctrl
  import sclk_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [NSRC-1:0]  wake_src,
  input  logic             wake_clr,
  output logic             clk_en,
  output logic             stop_req
);
  ctl_t             ctl_q;
  logic             any_src;
  logic             sb_clear_ev;
  logic             pm_blocked;
  logic [CNT_W-1:0] req_m1;
  logic [CNT_W-1:0] cur_m1;
  logic             unused_resv;

  assign unused_resv = ^wr_data[REG_W-1:USED_W];

  sclk_src_or #(.NSRC(NSRC)) src_or_i (
    .src     (wake_src),
    .any_src (any_src)
  );

  sclk_ctl_reg ctl_reg_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_bits     (wr_data[USED_W-1:0]),
    .any_src     (any_src),
    .wake_clr    (wake_clr),
    .ctl_q       (ctl_q),
    .sb_clear_ev (sb_clear_ev),
    .pm_blocked  (pm_blocked)
  );

  assign req_m1 = period_m1(ctl_q);

  sclk_en_gen en_gen_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_m1 (req_m1),
    .clk_en (clk_en),
    .cur_m1 (cur_m1)
  );

  assign rd_data  = {{(REG_W-USED_W){1'b0}}, ctl_q};
  assign stop_req = ctl_q.stop;
endmodule

// File: rtl/sclk_chk.sv
module sclk_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_stop,
  input logic             wake_clr,
  input logic [7:0]       rd_data,
  input logic             clk_en,
  input logic             stop_req,
  input logic [4:0]       ctl_bits,
  input logic             sb_clear_ev,
  input logic             pm_blocked,
  input logic [CNT_W-1:0] cur_m1
);
  logic [CNT_W-1:0] since_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clk_en) since_q <= '0;
    else                  since_q <= since_q + CNT_W'(1);
  end

  p_resv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:5] == 3'b000);

  p_div_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_bits[2] |=> $stable(ctl_bits[1:0]));

  p_sb_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && sb_clear_ev) |=> !ctl_bits[2]);

  p_pm_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pm_blocked |=> !ctl_bits[2]);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !wake_clr && !sb_clear_ev) |=> $stable(ctl_bits));

  p_stop_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_stop && !wake_clr) |=> stop_req);

  p_wake_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_clr |=> !stop_req);

  p_pm_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && ctl_bits[2]) |=> (cur_m1 == '1));

  p_div8_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !ctl_bits[2] && ctl_bits[1:0] == 2'b11) |=> (cur_m1 == CNT_W'(7)));

  p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> (since_q == cur_m1));
endmodule

bind sysclk_div_ctrl sclk_chk #(.CNT_W(sclk_pkg::CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_stop     (wr_data[4]),
  .wake_clr    (wake_clr),
  .rd_data     (rd_data),
  .clk_en      (clk_en),
  .stop_req    (stop_req),
  .ctl_bits    (ctl_q),
  .sb_clear_ev (sb_clear_ev),
  .pm_blocked  (pm_blocked),
  .cur_m1      (cur_m1)
);

// File: tb/sysclk_div_ctrl_tb_top.sv
module sysclk_div_ctrl_tb_top;
  localparam int NSRC = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [7:0]      wr_data = 8'h00;
  logic [NSRC-1:0] wake_src = '0;
  logic            wake_clr = 1'b0;
  logic [7:0]      rd_data;
  logic            clk_en;
  logic            stop_req;

  sysclk_div_ctrl #(.NSRC(NSRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wake_src(wake_src), .wake_clr(wake_clr),
    .clk_en(clk_en), .stop_req(stop_req)
  );

  always #2 clk = ~clk;   // 250 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int         due;
    bit         is_stop;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb_q[$];

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: compares scoreboard items in the cycle they fall due
  item_t it;
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      it = sb_q.pop_front();
      if (it.due == cyc) begin
        if (it.is_stop) check(it.req, "stop_req", int'(stop_req), int'(it.exp));
        else            check(it.req, "rd_data", int'(rd_data), int'(it.exp));
      end
    end
  end

  task automatic push(input bit is_stop, input logic [7:0] exp, input string req);
    item_t x;
    x.due = cyc + 1; x.is_stop = is_stop; x.exp = exp; x.req = req;
    sb_q.push_back(x);
  endtask

  // called at a negedge; returns at the next negedge
  task automatic write_reg(input logic [7:0] d, input logic [7:0] exp, input string req);
    wr_en = 1'b1; wr_data = d;
    push(1'b0, exp, req);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_next(input logic [7:0] exp, input string req);
    push(1'b0, exp, req);
    @(negedge clk);
  endtask

  task automatic measure(input int exp_n, input string req);
    int n;
    n = 0;
    while (!clk_en && n < 600) begin @(negedge clk); n++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!clk_en && n < 600);
    check(req, "pulse gap", n, exp_n);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "reset rd_data", int'(rd_data), 0);
    check("R8", "reset stop_req", int'(stop_req), 0);
    check("R9", "enable high after reset", int'(clk_en), 1);
    measure(1, "R9");

    // R1 divide selections
    write_reg(8'h01, 8'h01, "R1"); measure(2, "R1");
    write_reg(8'h02, 8'h02, "R1"); measure(4, "R1");
    write_reg(8'h03, 8'h03, "R1"); measure(8, "R1");

    // R10: write at a pulse; the running gap keeps the old divide
    begin
      int k;
      write_reg(8'h00, 8'h00, "R10");
      k = 1;
      while (!clk_en && k < 600) begin @(negedge clk); k++; end
      check("R10", "gap after change", k, 8);
    end
    measure(1, "R10");

    // R8 reserved bits
    write_reg(8'hE1, 8'h01, "R8"); measure(2, "R8");

    // R2 power-saving divide
    write_reg(8'h05, 8'h05, "R2"); measure(256, "R2");

    // R3 lock of divide select
    write_reg(8'h07, 8'h05, "R3"); measure(256, "R3");
    write_reg(8'h03, 8'h01, "R3"); measure(2, "R3");

    // R6 switchback inert without power-saving mode
    write_reg(8'h09, 8'h09, "R6");
    wake_src = 4'b0001;
    repeat (3) @(negedge clk);
    expect_next(8'h09, "R6");
    measure(2, "R6");
    // R6 switchback disabled: mode enters despite active source
    write_reg(8'h05, 8'h05, "R6");
    repeat (3) @(negedge clk);
    expect_next(8'h05, "R6");
    measure(256, "R6");
    wake_src = '0;
    @(negedge clk);

    // R4 hardware switchback
    write_reg(8'h0D, 8'h0D, "R4");
    wake_src = 4'b0100;
    expect_next(8'h09, "R4");
    measure(2, "R4");

    // R5 refusal while a source is active, acceptance once it drops
    write_reg(8'h0D, 8'h09, "R5");
    wake_src = '0;
    @(negedge clk);
    write_reg(8'h0D, 8'h0D, "R5");

    // R7 stop request
    push(1'b1, 8'h01, "R7");
    write_reg(8'h1D, 8'h1D, "R7");
    measure(256, "R7");
    wake_clr = 1'b1;
    push(1'b1, 8'h00, "R7");
    expect_next(8'h0D, "R7");
    wake_clr = 1'b0;
    wake_clr = 1'b1;
    push(1'b1, 8'h00, "R7");
    write_reg(8'h1D, 8'h0D, "R7");
    wake_clr = 1'b0;
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule